// File: doc/BRIEF.md
# Raster Timing Generator with Frame-Synchronous Register Shadowing

This block produces the line and frame timing for a parallel RGB panel: horizontal sync, vertical sync, data-enable and a pixel-valid strobe, plus an output that selects which pixel-clock edge launches data. Software programs the geometry of both axes through a small word-addressed register port. Each axis is set by four values: the visible count, the front porch, the sync pulse width and the back porch. Four independent bits select the polarity of each output.

The frame buffer base address and the layer enable are double-buffered. Software writes the pending copy and then raises a commit bit. The live copy moves at the next frame wrap and never mid-frame. Turning the layer off is also deferred: the enable bit keeps reading as one until the frame in flight has ended, so a driver can poll it to learn when scan-out has really stopped.

A vertical-blank status bit is set each time scanning leaves the last visible line. Writing one to it clears it. A separate enable bit gates it onto the interrupt line. A display-on bit and a soft-reset bit (the latter reachable through set and clear aliases of the control word) start and stop the counters.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the control, display-on, layer, base, status and interrupt-enable registers read zero, the size register (address 3) reads the default geometry as vertical visible count in bits 31:16 and horizontal visible count in bits 15:0, all timing outputs sit at their inactive level and irq_o is low.
- R2: A line lasts hact+hfp+hsw+hbp clocks, taken in the order visible, front porch, sync, back porch. Data-enable covers the first hact clocks of a visible line, and hsync is asserted for hsw clocks starting hact+hfp clocks after the line begins. Horizontal timing lives at address 4 with front porch in bits 7:0, pulse width in bits 15:8 and back porch in bits 23:16.
- R3: A frame lasts vact+vfp+vsw+vbp lines in the same order (address 5, same field layout). Vsync is asserted for whole lines starting at line vact+vfp. Data-enable is asserted for exactly hact*vact clocks per frame, and the pattern repeats from the first visible pixel after the frame wraps.
- R4: Control register (address 0) bits 1, 2, 3 and 4 invert hsync_o, vsync_o, de_o and pclk_inv_o respectively, both while idle and while scanning.
- R5: The display-on bit (address 6 bit 0) gates scanning. While it is zero the counters hold at the first pixel and hsync, vsync and data-enable stay inactive.
- R6: Control bit 0 is a soft reset. Address 1 ORs the written value into the control word and address 2 clears the written ones. While set, the timing returns to the first pixel with inactive outputs. Releasing it restarts scanning at the first visible pixel.
- R7: Writing one to layer register (address 7) bit 1 requests a commit. The pending base address (address 8) appears on fb_base_o only at the next frame wrap, and the commit bit reads one until then and zero afterwards.
- R8: A commit requested while the pending layer enable (address 7 bit 0) is zero stays pending across frame wraps and leaves fb_base_o unchanged.
- R9: Layer enable changes reach layer_live_o only at a frame wrap. After software clears the enable, address 7 bit 0 keeps reading one until that wrap.
- R10: Status bit (address 9 bit 0) is set when scanning enters the vertical front porch and is cleared by writing one to it. irq_o is high only while both that bit and the interrupt enable (address 10 bit 0) are one.
- R11: pix_valid_o is high only where data-enable is active and the live layer is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data-enable after polarity |
| pix_valid_o | output | 1 | Visible pixel of an enabled layer, active high |
| pclk_inv_o | output | 1 | Selects the opposite pixel-clock launch edge |
| fb_base_o | output | AW | Live frame buffer base address |
| layer_live_o | output | 1 | Live layer enable |
| irq_o | output | 1 | Vertical-blank interrupt |

## Verification
A table of four geometries is swept: a wide line with a two-clock pulse, a narrow line whose sync is longer than both porches, the minimum geometry with every field at one, and a tall frame whose vertical pulse spans two lines. For each, the bench counts enable, hsync and vsync clocks over one frame and records the first clock of each pulse, so a swapped porch order, an off-by-one wrap or a wrong axis step shows as a count or position mismatch. Directed runs then cover the polarity inversions, the soft-reset aliases, interrupt gating and the timed sequence of commits, deferred disables and a commit held back by a clear enable.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   localparam int unsigned MAX_CW = 16;
   localparam int unsigned MAX_PW = 8;

   // geometry of one scan axis, widths at their maximum
   typedef struct packed {
      logic [MAX_CW-1:0] act;
      logic [MAX_PW-1:0] fp;
      logic [MAX_PW-1:0] sw;
      logic [MAX_PW-1:0] bp;
   } axis_cfg_t;

   // control word; sw_rst is bit 0
   typedef struct packed {
      logic inv_pclk;
      logic inv_de;
      logic inv_vs;
      logic inv_hs;
      logic sw_rst;
   } ctrl_t;

   typedef enum logic [3:0] {
      RA_CTRL     = 4'd0,
      RA_CTRL_SET = 4'd1,
      RA_CTRL_CLR = 4'd2,
      RA_SIZE     = 4'd3,
      RA_HTIM     = 4'd4,
      RA_VTIM     = 4'd5,
      RA_DISP     = 4'd6,
      RA_LAYER    = 4'd7,
      RA_BASE     = 4'd8,
      RA_STAT     = 4'd9,
      RA_IEN      = 4'd10
   } reg_addr_e;

endpackage

// File: rtl/dtg_axis.sv
module dtg_axis
   import dtg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  logic      step,
   input  axis_cfg_t cfg,
   output logic      wrap,
   output logic      in_act,
   output logic      in_sync
);

   localparam int unsigned TW = MAX_CW + 2;

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] b_act, b_fp, b_sw, b_tot;

   // region boundaries: visible, front porch, sync, back porch
   always_comb begin
      b_act = TW'(cfg.act);
      b_fp  = b_act + TW'(cfg.fp);
      b_sw  = b_fp  + TW'(cfg.sw);
      b_tot = b_sw  + TW'(cfg.bp);
   end

   assign wrap    = (cnt_q == b_tot - TW'(1));
   assign in_act  = (cnt_q < b_act);
   assign in_sync = (cnt_q >= b_fp) && (cnt_q < b_sw);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else if (step)
         cnt_q <= wrap ? '0 : cnt_q + TW'(1);
   end

endmodule

// File: rtl/dtg_regs.sv
module dtg_regs
   import dtg_pkg::*;
#(
   parameter int unsigned CW       = 12,
   parameter int unsigned PW       = 8,
   parameter int unsigned AW       = 32,
   parameter int unsigned DEF_HACT = 8,
   parameter int unsigned DEF_HFP  = 2,
   parameter int unsigned DEF_HSW  = 2,
   parameter int unsigned DEF_HBP  = 2,
   parameter int unsigned DEF_VACT = 4,
   parameter int unsigned DEF_VFP  = 1,
   parameter int unsigned DEF_VSW  = 1,
   parameter int unsigned DEF_VBP  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [3:0]    addr,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata,
   input  logic          frame_end,
   input  logic          vblank_evt,
   output axis_cfg_t     hcfg,
   output axis_cfg_t     vcfg,
   output ctrl_t         ctrl,
   output logic          disp_on,
   output logic [AW-1:0] live_base,
   output logic          live_en,
   output logic          stat,
   output logic          ien
);

   localparam axis_cfg_t H_RST = '{act: MAX_CW'(DEF_HACT), fp: MAX_PW'(DEF_HFP),
                                   sw: MAX_PW'(DEF_HSW),   bp: MAX_PW'(DEF_HBP)};
   localparam axis_cfg_t V_RST = '{act: MAX_CW'(DEF_VACT), fp: MAX_PW'(DEF_VFP),
                                   sw: MAX_PW'(DEF_VSW),   bp: MAX_PW'(DEF_VBP)};

   ctrl_t         ctrl_q;
   axis_cfg_t     hcfg_q, vcfg_q;
   logic          disp_q;
   logic          shd_en_q, pend_q, live_en_q;
   logic [AW-1:0] shd_base_q, live_base_q;
   logic          stat_q, ien_q;
   reg_addr_e     wa;

   assign wa = reg_addr_e'(addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         hcfg_q      <= H_RST;
         vcfg_q      <= V_RST;
         disp_q      <= 1'b0;
         shd_en_q    <= 1'b0;
         pend_q      <= 1'b0;
         live_en_q   <= 1'b0;
         shd_base_q  <= '0;
         live_base_q <= '0;
         stat_q      <= 1'b0;
         ien_q       <= 1'b0;
      end else begin
         // frame-boundary transfer of the shadowed layer state
         if (ctrl_q.sw_rst) begin
            live_en_q <= 1'b0;
            pend_q    <= 1'b0;
         end else if (frame_end) begin
            live_en_q <= shd_en_q;
            if (pend_q && shd_en_q) begin
               live_base_q <= shd_base_q;
               pend_q      <= 1'b0;
            end
         end

         if (wr) begin
            case (wa)
               RA_CTRL:     ctrl_q <= ctrl_t'(wdata[4:0]);
               RA_CTRL_SET: ctrl_q <= ctrl_t'(ctrl_q | wdata[4:0]);
               RA_CTRL_CLR: ctrl_q <= ctrl_t'(ctrl_q & ~wdata[4:0]);
               RA_SIZE: begin
                  hcfg_q.act <= MAX_CW'(wdata[CW-1:0]);
                  vcfg_q.act <= MAX_CW'(wdata[16+CW-1:16]);
               end
               RA_HTIM: begin
                  hcfg_q.fp <= MAX_PW'(wdata[PW-1:0]);
                  hcfg_q.sw <= MAX_PW'(wdata[8+PW-1:8]);
                  hcfg_q.bp <= MAX_PW'(wdata[16+PW-1:16]);
               end
               RA_VTIM: begin
                  vcfg_q.fp <= MAX_PW'(wdata[PW-1:0]);
                  vcfg_q.sw <= MAX_PW'(wdata[8+PW-1:8]);
                  vcfg_q.bp <= MAX_PW'(wdata[16+PW-1:16]);
               end
               RA_DISP:  disp_q <= wdata[0];
               RA_LAYER: begin
                  shd_en_q <= wdata[0];
                  if (wdata[1]) pend_q <= 1'b1;
               end
               RA_BASE: shd_base_q <= wdata[AW-1:0];
               RA_STAT: if (wdata[0]) stat_q <= 1'b0;
               RA_IEN:  ien_q <= wdata[0];
               default: ;
            endcase
         end

         // a new blanking event wins over a same-cycle clear
         if (ctrl_q.sw_rst)
            stat_q <= 1'b0;
         else if (vblank_evt)
            stat_q <= 1'b1;
      end
   end

   always_comb begin
      rdata = '0;
      case (wa)
         RA_CTRL, RA_CTRL_SET, RA_CTRL_CLR: rdata = {27'd0, ctrl_q};
         RA_SIZE:  rdata = {vcfg_q.act, hcfg_q.act};
         RA_HTIM:  rdata = {8'd0, hcfg_q.bp, hcfg_q.sw, hcfg_q.fp};
         RA_VTIM:  rdata = {8'd0, vcfg_q.bp, vcfg_q.sw, vcfg_q.fp};
         RA_DISP:  rdata = {31'd0, disp_q};
         RA_LAYER: rdata = {30'd0, pend_q, shd_en_q | live_en_q};
         RA_BASE:  rdata = 32'(shd_base_q);
         RA_STAT:  rdata = {31'd0, stat_q};
         RA_IEN:   rdata = {31'd0, ien_q};
         default:  rdata = '0;
      endcase
   end

   assign hcfg      = hcfg_q;
   assign vcfg      = vcfg_q;
   assign ctrl      = ctrl_q;
   assign disp_on   = disp_q;
   assign live_base = live_base_q;
   assign live_en   = live_en_q;
   assign stat      = stat_q;
   assign ien       = ien_q;

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
   import dtg_pkg::*;
#(
   parameter int unsigned CW       = 12,
   parameter int unsigned PW       = 8,
   parameter int unsigned AW       = 32,
   parameter int unsigned OUT_REG  = 0,
   parameter int unsigned DEF_HACT = 8,
   parameter int unsigned DEF_HFP  = 2,
   parameter int unsigned DEF_HSW  = 2,
   parameter int unsigned DEF_HBP  = 2,
   parameter int unsigned DEF_VACT = 4,
   parameter int unsigned DEF_VFP  = 1,
   parameter int unsigned DEF_VSW  = 1,
   parameter int unsigned DEF_VBP  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [3:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          de_o,
   output logic          pix_valid_o,
   output logic          pclk_inv_o,
   output logic [AW-1:0] fb_base_o,
   output logic          layer_live_o,
   output logic          irq_o
);

   // elaboration-time parameter checks
   if (CW < 2 || CW > MAX_CW) begin : g_bad_cw
      $error("disp_timing_gen: CW out of range");
   end
   if (PW < 1 || PW > MAX_PW) begin : g_bad_pw
      $error("disp_timing_gen: PW out of range");
   end
   if (AW < 1 || AW > 32) begin : g_bad_aw
      $error("disp_timing_gen: AW out of range");
   end
   if (OUT_REG > 1) begin : g_bad_oreg
      $error("disp_timing_gen: OUT_REG must be 0 or 1");
   end

   axis_cfg_t hcfg, vcfg;
   ctrl_t     ctrl;
   logic      disp_on, live_en, stat, ien;
   logic      sw_rst, inv_hs, inv_vs, inv_de;
   logic      run, frame_end, vblank_evt;
   logic      h_wrap, h_act, h_syn;
   logic      v_wrap, v_act, v_syn, v_act_q;
   logic      de_raw, hs_raw, vs_raw, pv_raw;

   assign sw_rst = ctrl.sw_rst;
   assign inv_hs = ctrl.inv_hs;
   assign inv_vs = ctrl.inv_vs;
   assign inv_de = ctrl.inv_de;

   dtg_regs #(
      .CW(CW), .PW(PW), .AW(AW),
      .DEF_HACT(DEF_HACT), .DEF_HFP(DEF_HFP), .DEF_HSW(DEF_HSW), .DEF_HBP(DEF_HBP),
      .DEF_VACT(DEF_VACT), .DEF_VFP(DEF_VFP), .DEF_VSW(DEF_VSW), .DEF_VBP(DEF_VBP)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .rdata      (reg_rdata),
      .frame_end  (frame_end),
      .vblank_evt (vblank_evt),
      .hcfg       (hcfg),
      .vcfg       (vcfg),
      .ctrl       (ctrl),
      .disp_on    (disp_on),
      .live_base  (fb_base_o),
      .live_en    (live_en),
      .stat       (stat),
      .ien        (ien)
   );

   assign run = disp_on & ~sw_rst;

   dtg_axis u_hax (
      .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1), .cfg(hcfg),
      .wrap(h_wrap), .in_act(h_act), .in_sync(h_syn)
   );

   dtg_axis u_vax (
      .clk(clk), .rst_n(rst_n), .run(run), .step(h_wrap), .cfg(vcfg),
      .wrap(v_wrap), .in_act(v_act), .in_sync(v_syn)
   );

   assign frame_end = run & h_wrap & v_wrap;

   // falling edge of the vertical visible region marks front-porch entry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_act_q <= 1'b1;
      else        v_act_q <= v_act;
   end
   assign vblank_evt = run & v_act_q & ~v_act;

   assign de_raw = run & h_act & v_act;
   assign hs_raw = run & h_syn;
   assign vs_raw = run & v_syn;
   assign pv_raw = de_raw & live_en;

   if (OUT_REG != 0) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hsync_o     <= 1'b0;
            vsync_o     <= 1'b0;
            de_o        <= 1'b0;
            pix_valid_o <= 1'b0;
         end else begin
            hsync_o     <= hs_raw ^ inv_hs;
            vsync_o     <= vs_raw ^ inv_vs;
            de_o        <= de_raw ^ inv_de;
            pix_valid_o <= pv_raw;
         end
      end
   end else begin : g_out_comb
      assign hsync_o     = hs_raw ^ inv_hs;
      assign vsync_o     = vs_raw ^ inv_vs;
      assign de_o        = de_raw ^ inv_de;
      assign pix_valid_o = pv_raw;
   end

   assign pclk_inv_o   = ctrl.inv_pclk;
   assign layer_live_o = live_en;
   assign irq_o        = stat & ien;

endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
   parameter int unsigned AW      = 32,
   parameter int unsigned OUT_REG = 0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          run,
   input logic          sw_rst,
   input logic          frame_end,
   input logic          vblank_evt,
   input logic          stat,
   input logic          inv_de,
   input logic          inv_hs,
   input logic          de_o,
   input logic          hsync_o,
   input logic          pix_valid_o,
   input logic          layer_live_o,
   input logic [AW-1:0] fb_base_o
);

   // R7: the live base moves only right after a frame wrap
   a_r7_base_moves_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fb_base_o) |-> $past(frame_end));

   // R9: the live layer drops only at a frame wrap or by soft reset
   a_r9_layer_drops_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(layer_live_o) |-> ($past(frame_end) || $past(sw_rst)));

   // R10: status rises only after a front-porch entry event
   a_r10_status_from_vblank: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat) |-> $past(vblank_evt));

   if (OUT_REG == 0) begin : g_comb_chk
      // R5: outputs at inactive level while stopped
      a_r5_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
         !run |-> ((de_o == inv_de) && (hsync_o == inv_hs)));

      // R2: visible region and horizontal sync never overlap
      a_r2_de_excludes_hsync: assert property (@(posedge clk) disable iff (!rst_n)
         (de_o != inv_de) |-> (hsync_o == inv_hs));

      // R11: pixel-valid only inside data-enable
      a_r11_pv_inside_de: assert property (@(posedge clk) disable iff (!rst_n)
         pix_valid_o |-> (de_o != inv_de));
   end

endmodule

bind disp_timing_gen dtg_checker #(.AW(AW), .OUT_REG(OUT_REG)) u_dtg_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .run          (run),
   .sw_rst       (sw_rst),
   .frame_end    (frame_end),
   .vblank_evt   (vblank_evt),
   .stat         (stat),
   .inv_de       (inv_de),
   .inv_hs       (inv_hs),
   .de_o         (de_o),
   .hsync_o      (hsync_o),
   .pix_valid_o  (pix_valid_o),
   .layer_live_o (layer_live_o),
   .fb_base_o    (fb_base_o)
);

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   localparam logic [3:0] A_CTRL = 4'd0, A_SET = 4'd1, A_CLR = 4'd2, A_SIZE = 4'd3,
                          A_HTIM = 4'd4, A_VTIM = 4'd5, A_DISP = 4'd6, A_LAYER = 4'd7,
                          A_BASE = 4'd8, A_STAT = 4'd9, A_IEN = 4'd10;

   // hact hfp hsw hbp vact vfp vsw vbp exp_de exp_hs exp_vs
   localparam int VEC [4][11] = '{
      '{ 8, 2, 2, 2, 4, 1, 1, 2, 32, 16, 14},
      '{ 5, 1, 3, 1, 3, 2, 1, 1, 15, 21, 10},
      '{ 1, 1, 1, 1, 1, 1, 1, 1,  1,  4,  4},
      '{12, 3, 1, 4, 6, 2, 2, 3, 72, 13, 40}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          hsync_o, vsync_o, de_o, pix_valid_o, pclk_inv_o, layer_live_o, irq_o;
   logic [AW-1:0] fb_base_o;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   disp_timing_gen u_disp_timing_gen (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync_o(hsync_o),
      .vsync_o(vsync_o), .de_o(de_o), .pix_valid_o(pix_valid_o),
      .pclk_inv_o(pclk_inv_o), .fb_base_o(fb_base_o),
      .layer_live_o(layer_live_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
      cyc++;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_to(input int idx);
      while (cyc < idx) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic start_disp();
      wr(A_DISP, 32'd1);
      cyc = 0;
   endtask

   task automatic load_geom(input int k);
      wr(A_SIZE, (VEC[k][4] << 16) | VEC[k][0]);
      wr(A_HTIM, (VEC[k][3] << 16) | (VEC[k][2] << 8) | VEC[k][1]);
      wr(A_VTIM, (VEC[k][7] << 16) | (VEC[k][6] << 8) | VEC[k][5]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      rd(A_CTRL, r);  chk("R1 ctrl", r, 32'd0);
      rd(A_LAYER, r); chk("R1 layer", r, 32'd0);
      rd(A_STAT, r);  chk("R1 status", r, 32'd0);
      rd(A_DISP, r);  chk("R1 display-on", r, 32'd0);
      rd(A_SIZE, r);  chk("R1 size", r, 32'h0004_0008);
      chk("R1 idle outputs", {hsync_o, vsync_o, de_o, pix_valid_o, irq_o}, 32'd0);
      chk("R1 base", fb_base_o, 32'd0);

      // R2 / R3: geometry table
      for (int k = 0; k < 4; k++) begin
         int htot, vtot, nde, nhs, nvs, fhs, fvs;
         htot = VEC[k][0] + VEC[k][1] + VEC[k][2] + VEC[k][3];
         vtot = VEC[k][4] + VEC[k][5] + VEC[k][6] + VEC[k][7];
         nde = 0; nhs = 0; nvs = 0; fhs = -1; fvs = -1;
         wr(A_SET, 32'd1);
         load_geom(k);
         wr(A_CLR, 32'd1);
         start_disp();
         for (int i = 0; i < htot * vtot; i++) begin
            if (de_o) nde++;
            if (hsync_o) begin nhs++; if (fhs < 0) fhs = i; end
            if (vsync_o) begin nvs++; if (fvs < 0) fvs = i; end
            @(negedge clk);
            cyc++;
         end
         chk("R3 de clocks per frame", nde, VEC[k][8]);
         chk("R2 hsync clocks per frame", nhs, VEC[k][9]);
         chk("R3 vsync clocks per frame", nvs, VEC[k][10]);
         chk("R2 first hsync clock", fhs, VEC[k][0] + VEC[k][1]);
         chk("R3 first vsync clock", fvs, (VEC[k][4] + VEC[k][5]) * htot);
         chk("R3 frame wraps to visible pixel", de_o, 32'd1);
         wr(A_DISP, 32'd0);
      end

      load_geom(0);

      // R4: polarity inversion, idle and scanning
      wr(A_SET, 32'h1E);
      rd(A_CTRL, r); chk("R4 ctrl readback", r, 32'h1E);
      chk("R4 idle inverted", {hsync_o, vsync_o, de_o, pclk_inv_o}, 32'hF);
      begin
         int lo_de, lo_hs;
         lo_de = 0; lo_hs = 0;
         start_disp();
         for (int i = 0; i < 112; i++) begin
            if (!de_o) lo_de++;
            if (!hsync_o) lo_hs++;
            @(negedge clk);
            cyc++;
         end
         chk("R4 inverted de clocks", lo_de, 32);
         chk("R4 inverted hsync clocks", lo_hs, 16);
      end
      wr(A_DISP, 32'd0);
      wr(A_CLR, 32'h1E);
      chk("R4 polarity restored", {hsync_o, vsync_o, de_o, pclk_inv_o}, 32'd0);

      // R6: soft reset via aliases
      start_disp();
      wait_to(3);
      chk("R6 scanning before soft reset", de_o, 32'd1);
      wr(A_SET, 32'd1);
      rd(A_CTRL, r); chk("R6 set alias", r, 32'd1);
      wait_to(9);
      chk("R6 outputs idle in soft reset", {hsync_o, vsync_o, de_o}, 32'd0);
      wr(A_CLR, 32'd1);
      rd(A_CTRL, r); chk("R6 clear alias", r, 32'd0);
      chk("R6 restart at first pixel", de_o, 32'd1);
      wr(A_DISP, 32'd0);

      // R5: display-on gating
      wait_to(cyc + 20);
      chk("R5 stopped outputs idle", {hsync_o, vsync_o, de_o}, 32'd0);

      // R10: vertical blank status and gating
      wr(A_IEN, 32'd1);
      start_disp();
      wait_to(56);
      rd(A_STAT, r); chk("R10 status before porch", r, 32'd0);
      wait_to(57);
      rd(A_STAT, r); chk("R10 status at porch", r, 32'd1);
      chk("R10 irq enabled", irq_o, 32'd1);
      wr(A_STAT, 32'd1);
      rd(A_STAT, r); chk("R10 write-one clear", r, 32'd0);
      chk("R10 irq after clear", irq_o, 32'd0);
      wr(A_IEN, 32'd0);
      wait_to(169);
      rd(A_STAT, r); chk("R10 status second frame", r, 32'd1);
      chk("R10 irq gated off", irq_o, 32'd0);
      wr(A_STAT, 32'd1);

      // R8: commit held while pending enable is clear
      wr(A_BASE, 32'h0000_A000);
      wr(A_LAYER, 32'd2);
      wait_to(225);
      chk("R8 base unchanged", fb_base_o, 32'd0);
      rd(A_LAYER, r); chk("R8 commit still pending", r, 32'd2);

      // R7 / R9 / R11: enable and commit at frame wrap
      wr(A_LAYER, 32'd1);
      rd(A_LAYER, r); chk("R9 enable reads set", r, 32'd3);
      wait_to(335);
      chk("R9 layer not live mid-frame", layer_live_o, 32'd0);
      chk("R11 no pixel-valid without layer", pix_valid_o, 32'd0);
      wait_to(336);
      chk("R9 layer live after wrap", layer_live_o, 32'd1);
      chk("R7 pending base applied", fb_base_o, 32'h0000_A000);
      rd(A_LAYER, r); chk("R7 commit bit cleared", r, 32'd1);
      chk("R11 pixel-valid with layer", pix_valid_o, 32'd1);
      wr(A_BASE, 32'h0000_B000);
      wr(A_LAYER, 32'd3);
      wait_to(447);
      chk("R7 base held mid-frame", fb_base_o, 32'h0000_A000);
      rd(A_LAYER, r); chk("R7 commit bit pending", r, 32'd3);
      wait_to(448);
      chk("R7 base at wrap", fb_base_o, 32'h0000_B000);
      wr(A_LAYER, 32'd0);
      wait_to(500);
      rd(A_LAYER, r); chk("R9 cleared enable reads set", r, 32'd1);
      wait_to(559);
      chk("R9 layer live until wrap", layer_live_o, 32'd1);
      wait_to(560);
      rd(A_LAYER, r); chk("R9 enable reads clear after wrap", r, 32'd0);
      chk("R9 layer stopped", layer_live_o, 32'd0);
      chk("R11 de active", de_o, 32'd1);
      chk("R11 pixel-valid off", pix_valid_o, 32'd0);
      wr(A_DISP, 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule